// File: doc/BRIEF.md
# Rainbow Chain Precomputation Engine

This block builds chains for a time-memory trade-off table. Over a configured range of 56-bit start points, it takes each start point as a key. It encrypts one fixed chosen plaintext under that key and folds the 64-bit result back into a 56-bit key with a column-dependent reduction. It repeats this for a configured number of steps and then reports the pair of the chain's start point and its final point. Storing the pairs is left to the logic downstream.

The cipher is a fixed-latency pipeline of `LAT` stages. Every pipeline slot carries one chain, so `LAT` chains are in flight at once and one chain step completes per clock. A selector at the pipeline entry either reinjects the reduced point of the chain leaving the pipeline or, when that chain has just finished or the slot is empty, takes a fresh start point. In this project the cipher is a simple stand-in function with the same interface and latency as a real one.

A high `enable` with the engine idle latches the plaintext (after the input permutation), the masks, the range and the chain length, and starts the run. While `pause` is high nothing advances and no chain state is lost. `done` rises after the chain of the last start point has been reported and stays high until reset.

Top module: `rcp_engine`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `done` are 0 after that edge, and with `enable` held low nothing is reported.
- R2: Each start point from `first_start` to `last_start` inclusive (with `first_start <= last_start`) is reported exactly once on `out_start`, in increasing order, one `out_valid` pulse per chain.
- R3: With P = plaintext rotated left by 8 bits, the cipher stand-in is C(k) = (P XOR {k[27:0], k[55:20]}) + 64'h9E3779B97F4A7C15 (mod 2^64). The ciphertext is rotated right by 8 bits before reduction. The reported end point is k_len, where k_0 is the start point and k_(j+1) = ((rotr8(C(k_j))[55:0] XOR j) AND end_mask) OR start_mask.
- R4: Every reported end point has all bits of `start_mask` set and every bit outside `end_mask | start_mask` clear.
- R5: The reduction depends on the step number j (0 for the first step of a chain up to chain_len-1 for the last), zero-extended to 56 bits and XORed in before masking.
- R6: While `pause` is high at a rising edge, no chain advances and `out_valid` is 0 after it. A paused run reports the same pairs in the same order as an unpaused one.
- R7: `done` is low while chains are still being reported, rises after the last pair, and then stays high with no further `out_valid` pulse until reset.
- R8: Without pauses, the first pulse follows chain_len*LAT+1 rising edges after the edge that first samples `enable` high. The pair for start index i (counting from 0) comes (i div LAT)*chain_len*LAT + (i mod LAT) edges after the first pulse. At most LAT chains are in flight.
- R9: `chain_len` must be at least 1. Plaintext, masks, range and length are sampled only at the start of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Starts a run when the engine is idle |
| pause | input | 1 | Freezes all chain progress while high |
| plaintext | input | 64 | Chosen plaintext |
| first_start | input | 56 | First start point of the range |
| last_start | input | 56 | Last start point of the range |
| start_mask | input | 56 | Bits forced to 1 in every reduced key |
| end_mask | input | 56 | Bits kept from the ciphertext in every reduced key |
| chain_len | input | COL_W | Steps per chain (at least 1) |
| out_valid | output | 1 | One-cycle strobe for a finished chain |
| out_start | output | 56 | Start point of the finished chain |
| out_end | output | 56 | End point of the finished chain |
| done | output | 1 | All chains of the range reported |

## Verification
The hardest situation to reach is a slot being handed over: a chain finishes in the same cycle that a fresh start point takes its place, and a pause lands right on that boundary. The bench uses ranges longer than the pipeline depth, so every slot is recycled at least once. It then replays such a range with a pseudo-random pause pattern that freezes the engine at arbitrary slot positions, including hand-over cycles. Each reported end point is compared with an arithmetic chain model, so a slot that loses or repeats a step shows up as a wrong end point or a wrong pair order.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int KEY_W = 56;
    localparam int BLK_W = 64;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [BLK_W-1:0] blk_t;

    localparam blk_t MIX_CONST = 64'h9E37_79B9_7F4A_7C15;

    // entry into the cipher pipeline
    typedef struct packed {
        logic vld;
        key_t start;
        key_t key;
    } inj_t;

    // token carried along the pipeline
    typedef struct packed {
        logic vld;
        key_t start;
        blk_t blk;
    } tok_t;

    // input permutation of the plaintext (rotate left by one byte)
    function automatic blk_t perm_in(input blk_t x);
        return {x[BLK_W-9:0], x[BLK_W-1:BLK_W-8]};
    endfunction

    // inverse permutation of the ciphertext (rotate right by one byte)
    function automatic blk_t perm_out(input blk_t x);
        return {x[7:0], x[BLK_W-1:8]};
    endfunction

    // stand-in for the full round pipeline
    function automatic blk_t cipher_stub(input key_t k, input blk_t pp);
        blk_t spread;
        spread = {k[27:0], k[55:20]};
        return (pp ^ spread) + MIX_CONST;
    endfunction

    // column-dependent reduction back into the masked key space
    function automatic key_t reduce_key(input blk_t ct, input key_t col,
                                        input key_t smask, input key_t emask);
        blk_t unp;
        unp = perm_out(ct);
        return ((unp[KEY_W-1:0] ^ col) & emask) | smask;
    endfunction

endpackage

// File: rtl/rcp_start_gen.sv
module rcp_start_gen
    import rcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  key_t first,
    input  key_t last,
    input  logic take,
    output key_t cur,
    output logic have
);

    key_t cur_q;
    logic have_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            have_q <= 1'b0;
        end else if (load) begin
            cur_q  <= first;
            have_q <= 1'b1;
        end else if (take && have_q) begin
            if (cur_q >= last) begin
                have_q <= 1'b0;
            end else begin
                cur_q <= cur_q + key_t'(1);
            end
        end
    end

    assign cur  = cur_q;
    assign have = have_q;

endmodule

// File: rtl/rcp_cipher_pipe.sv
module rcp_cipher_pipe
    import rcp_pkg::*;
#(
    parameter int LAT   = 48,
    parameter int COL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  inj_t             inj,
    input  logic [COL_W-1:0] inj_col,
    input  blk_t             pp,
    output tok_t             tail,
    output logic [COL_W-1:0] tail_col
);

    tok_t             stg_q [LAT];
    logic [COL_W-1:0] col_q [LAT];

    generate
        for (genvar i = 0; i < LAT; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stg_q[0] <= '0;
                        col_q[0] <= '0;
                    end else if (adv) begin
                        stg_q[0].vld   <= inj.vld;
                        stg_q[0].start <= inj.start;
                        stg_q[0].blk   <= cipher_stub(inj.key, pp);
                        col_q[0]       <= inj_col;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        stg_q[i] <= '0;
                        col_q[i] <= '0;
                    end else if (adv) begin
                        stg_q[i] <= stg_q[i-1];
                        col_q[i] <= col_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign tail     = stg_q[LAT-1];
    assign tail_col = col_q[LAT-1];

endmodule

// File: rtl/rcp_reducer.sv
module rcp_reducer
    import rcp_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  blk_t             ct,
    input  logic [COL_W-1:0] col,
    input  key_t             smask,
    input  key_t             emask,
    output key_t             next_key
);

    key_t col_ext;

    always_comb begin
        col_ext  = key_t'(col);
        next_key = reduce_key(ct, col_ext, smask, emask);
    end

endmodule

// File: rtl/rcp_engine.sv
module rcp_engine
    import rcp_pkg::*;
#(
    parameter int LAT   = 48,
    parameter int COL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             pause,
    input  logic [63:0]      plaintext,
    input  logic [55:0]      first_start,
    input  logic [55:0]      last_start,
    input  logic [55:0]      start_mask,
    input  logic [55:0]      end_mask,
    input  logic [COL_W-1:0] chain_len,
    output logic             out_valid,
    output logic [55:0]      out_start,
    output logic [55:0]      out_end,
    output logic             done
);

    localparam int CNT_W = $clog2(LAT + 1);

    // run configuration, captured when a run starts
    logic             running_q;
    blk_t             pp_q;
    key_t             sm_q, em_q, first_q, last_q;
    logic [COL_W-1:0] len_q;

    logic [CNT_W-1:0] live_q;
    logic             done_q;
    logic             vld_q;
    key_t             ostart_q, oend_q;

    logic start_now, adv;
    assign start_now = enable & ~running_q;
    assign adv       = running_q & ~pause;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            pp_q      <= '0;
            sm_q      <= '0;
            em_q      <= '0;
            first_q   <= '0;
            last_q    <= '0;
            len_q     <= '0;
        end else if (start_now) begin
            running_q <= 1'b1;
            pp_q      <= perm_in(plaintext);
            sm_q      <= start_mask;
            em_q      <= end_mask;
            first_q   <= first_start;
            last_q    <= last_start;
            len_q     <= chain_len;
        end
    end

    // start point source
    key_t gen_cur;
    logic gen_have;
    logic take;

    rcp_start_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_now),
        .first (first_start),
        .last  (last_q),
        .take  (take),
        .cur   (gen_cur),
        .have  (gen_have)
    );

    // pipeline and its feedback
    inj_t             inj;
    logic [COL_W-1:0] inj_col;
    tok_t             tail;
    logic [COL_W-1:0] tail_col;
    key_t             next_key;
    logic [COL_W:0]   col_inc;
    logic             finishing, slot_free;

    rcp_cipher_pipe #(
        .LAT   (LAT),
        .COL_W (COL_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .inj      (inj),
        .inj_col  (inj_col),
        .pp       (pp_q),
        .tail     (tail),
        .tail_col (tail_col)
    );

    rcp_reducer #(
        .COL_W (COL_W)
    ) u_red (
        .ct       (tail.blk),
        .col      (tail_col),
        .smask    (sm_q),
        .emask    (em_q),
        .next_key (next_key)
    );

    assign col_inc   = {1'b0, tail_col} + {{COL_W{1'b0}}, 1'b1};
    assign finishing = tail.vld && (col_inc == {1'b0, len_q});
    assign slot_free = !tail.vld || finishing;
    assign take      = adv && slot_free && gen_have;

    // entry selector: recirculate a live chain or inject a fresh start point
    always_comb begin
        inj     = '0;
        inj_col = '0;
        if (tail.vld && !finishing) begin
            inj.vld   = 1'b1;
            inj.start = tail.start;
            inj.key   = next_key;
            inj_col   = col_inc[COL_W-1:0];
        end else if (gen_have) begin
            inj.vld   = 1'b1;
            inj.start = gen_cur;
            inj.key   = gen_cur;
            inj_col   = '0;
        end
    end

    // chains in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (adv) begin
            live_q <= live_q + CNT_W'(take) - CNT_W'(finishing);
        end
    end

    // result strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= 1'b0;
            ostart_q <= '0;
            oend_q   <= '0;
        end else begin
            vld_q <= adv && finishing;
            if (adv && finishing) begin
                ostart_q <= tail.start;
                oend_q   <= next_key;
            end
        end
    end

    // completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (running_q && !gen_have && live_q == '0) begin
            done_q <= 1'b1;
        end
    end

    assign out_valid = vld_q;
    assign out_start = ostart_q;
    assign out_end   = oend_q;
    assign done      = done_q;

endmodule

// File: rtl/rcp_engine_chk.sv
module rcp_engine_chk #(
    parameter int LAT   = 48,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pause,
    input logic             out_valid,
    input logic [55:0]      out_start,
    input logic [55:0]      out_end,
    input logic             done,
    input logic [55:0]      sm_q,
    input logic [55:0]      em_q,
    input logic [55:0]      first_q,
    input logic [55:0]      last_q,
    input logic [CNT_W-1:0] live_cnt
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!out_valid && !done)); // R1

    AST_START_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_start >= first_q && out_start <= last_q)); // R2

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_end & sm_q) == sm_q)); // R4

    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_end & ~(em_q | sm_q)) == 56'd0)); // R4

    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$past(pause)); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt <= CNT_W'(LAT)); // R8

endmodule

bind rcp_engine rcp_engine_chk #(
    .LAT   (LAT),
    .CNT_W ($clog2(LAT + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause     (pause),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_end   (out_end),
    .done      (done),
    .sm_q      (sm_q),
    .em_q      (em_q),
    .first_q   (first_q),
    .last_q    (last_q),
    .live_cnt  (live_q)
);

// File: tb/tb_rcp_engine.sv
module tb_rcp_engine;

    localparam int LAT   = 4;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             pause = 1'b0;
    logic [63:0]      plaintext = '0;
    logic [55:0]      first_start = '0;
    logic [55:0]      last_start = '0;
    logic [55:0]      start_mask = '0;
    logic [55:0]      end_mask = '0;
    logic [COL_W-1:0] chain_len = '0;
    logic             out_valid;
    logic [55:0]      out_start;
    logic [55:0]      out_end;
    logic             done;

    rcp_engine #(.LAT(LAT), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pause(pause),
        .plaintext(plaintext), .first_start(first_start), .last_start(last_start),
        .start_mask(start_mask), .end_mask(end_mask), .chain_len(chain_len),
        .out_valid(out_valid), .out_start(out_start), .out_end(out_end), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // chain model written from the requirement text
    function automatic logic [55:0] model_end(input logic [55:0] s, input logic [63:0] pt,
                                              input logic [55:0] sm, input logic [55:0] em,
                                              input int len);
        logic [63:0] pp, c, u;
        logic [55:0] k;
        pp = {pt[55:0], pt[63:56]};
        k  = s;
        for (int j = 0; j < len; j++) begin
            c = (pp ^ {k[27:0], k[55:20]}) + 64'h9E3779B97F4A7C15;
            u = {c[7:0], c[63:8]};
            k = ((u[55:0] ^ 56'(j)) & em) | sm;
        end
        return k;
    endfunction

    // monitor state
    bit          mon_on = 1'b0;
    bit          timing_on = 1'b0;
    int          idx = 0;
    int          c0 = 0;
    int          first_cyc = 0;
    logic [55:0] m_first, m_sm, m_em;
    logic [63:0] m_pt;
    int          m_len;

    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            logic [55:0] es, ee;
            es = m_first + 56'(idx);
            ee = model_end(es, m_pt, m_sm, m_em, m_len);
            chk(out_start == es, "R2 start order", 64'(out_start), 64'(es));
            chk(out_end == ee, "R3 R5 end point", 64'(out_end), 64'(ee));
            chk(((out_end & m_sm) == m_sm) && ((out_end & ~(m_sm | m_em)) == 56'd0),
                "R4 masks", 64'(out_end), 64'(ee));
            chk(!done, "R7 done early", 64'(done), 64'd0);
            chk(!pause, "R6 pulse while paused", 64'(pause), 64'd0);
            if (timing_on) begin
                int ec;
                ec = c0 + m_len * LAT + 2 + (idx / LAT) * m_len * LAT + (idx % LAT);
                chk(cyc == ec, "R8 pulse timing", 64'(cyc), 64'(ec));
            end
            idx++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        mon_on = 1'b0;
        rst_n  = 1'b0;
        enable = 1'b0;
        pause  = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_valid && !done, "R1 reset state", {62'd0, out_valid, done}, 64'd0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!out_valid && !done, "R1 idle without enable", {62'd0, out_valid, done}, 64'd0);
    endtask

    task automatic run_case(input logic [55:0] f, input logic [55:0] l, input int len,
                            input logic [55:0] sm, input logic [55:0] em,
                            input logic [63:0] pt, input bit with_pause);
        int n;
        logic [7:0] lfsr;
        n = int'(l - f) + 1;
        do_reset();
        m_first = f; m_sm = sm; m_em = em; m_pt = pt; m_len = len;
        idx = 0;
        timing_on = !with_pause;
        first_start = f; last_start = l; start_mask = sm; end_mask = em;
        plaintext = pt; chain_len = COL_W'(len);
        mon_on = 1'b1;
        #1;
        c0 = cyc;
        enable = 1'b1;
        lfsr = 8'hA5;
        for (int t = 0; t < 20000 && !done; t++) begin
            @(negedge clk);
            #1;
            // inputs changed after start must be ignored (R9)
            plaintext = ~pt;
            chain_len = COL_W'(len + 3);
            if (with_pause) begin
                lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                pause = lfsr[0] & lfsr[2];
            end
        end
        pause = 1'b0;
        @(negedge clk);
        chk(idx == n, "R2 chain count", 64'(idx), 64'(n));
        chk(done, "R7 done raised", 64'(done), 64'd1);
        repeat (6) @(negedge clk);
        chk(idx == n, "R7 no pulse after done", 64'(idx), 64'(n));
        chk(done, "R7 done held", 64'(done), 64'd1);
    endtask

    initial begin
        // recycled slots, 40-bit key space
        run_case(56'h10, 56'h1B, 3, 56'h0, 56'h00_00FF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 1'b0);
        // fewer starts than slots, single step, forced top bits
        run_case(56'hAB_0000_0000_0100, 56'hAB_0000_0000_0101, 1, 56'h5A_0000_0000_0000,
                 56'h00_0000_00FF_FFFF, 64'hFEDC_BA98_7654_3210, 1'b0);
        // same kind of range under a pseudo-random pause pattern (R6)
        run_case(56'h40, 56'h48, 5, 56'h80_0000_0000_0000, 56'h00_00FF_FFFF_FFFF,
                 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
        // single start point
        run_case(56'h77, 56'h77, 2, 56'h0, {56{1'b1}}, 64'h1111_2222_3333_4444, 1'b0);
        // sweep of chain lengths, unpaused and paused
        for (int len = 1; len <= 4; len++) begin
            run_case(56'h200, 56'h206, len, 56'h0, 56'h00_0000_FFFF_FFFF,
                     64'h0F0F_F0F0_5555_AAAA, 1'b0);
            run_case(56'h300, 56'h309, len, 56'h01, 56'h00_0000_0000_FFFF,
                     64'h8000_0000_0000_0001, 1'b1);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule